// File: doc/BRIEF.md
# Iterative Keccak-f[1600] Permutation Engine

This block applies the full 24-round Keccak-f[1600] permutation to a 1600-bit state. The state is 25 lanes of 64 bits. One complete round (theta, rho, pi, chi, iota) is evaluated combinationally per clock. A single state register carries the result from one round to the next. A round index picks the 64-bit round constant. Each constant is computed at elaboration from the Keccak LFSR, so no constant is written out by hand. The block has no padding, rate selection, message buffering or bus logic. It only permutes the state it is handed.

A client presents a state on `perm_state_i` and pulses `perm_go_i` while `perm_busy_o` is low. There is no valid/ready handshake on either side. The single back-pressure rule is that a go pulse seen while busy is dropped. The input word is sampled only on the edge that accepts the go pulse. The result is not held back for the consumer. It sits on `perm_state_o` from the `perm_done_o` pulse until the next accepted go pulse, and the consumer must capture it in that window. A new go pulse may be given in the same cycle as done, so permutations can follow each other every 24 cycles.

Top module: `keccak_f1600_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `perm_busy_o` and `perm_done_o` are 0 and `perm_state_o` is all zeros.
- R2: Lane (x,y) occupies bits [64*(x+5*y) +: 64] of both state ports, and bit 0 of a lane is its least significant bit.
- R3: After a permutation, `perm_state_o` equals Keccak-f[1600] of the accepted input. That is 24 rounds of theta, rho, pi, chi and iota with the standard rotation offsets and round constants (RC[0]=0x0000000000000001, RC[1]=0x0000000000008082, RC[23]=0x8000000080008008). For the all-zero input, lane (0,0) of the result is 0xF1258F7940E1DDE7.
- R4: A go pulse sampled on a rising edge while busy is low is accepted, and busy is high in the following cycle.
- R5: Counting the accepting edge as edge 1, done is high in the cycle after edge 24, and busy stays high for exactly the 23 cycles in between.
- R6: Done is a single-cycle pulse. It is high exactly in the cycle where busy has just fallen.
- R7: A go pulse sampled while busy is high is ignored. It changes neither the result nor the timing of the running permutation.
- R8: Once busy is low and no go pulse is accepted, `perm_state_o` holds its value whatever `perm_state_i` does.
- R9: A go pulse given in the cycle where done is high is accepted. This gives back-to-back permutations with a 24-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| perm_go_i | input | 1 | Start request; accepted only while busy is low |
| perm_state_i | input | 1600 | State to permute, sampled on the accepting edge |
| perm_busy_o | output | 1 | High while rounds 2 to 24 are pending |
| perm_done_o | output | 1 | One-cycle pulse when the final state is present |
| perm_state_o | output | 1600 | Working register; holds the permuted state after done |

## Verification
Rounds diffuse every bit across the whole state within a few steps. A wrong lane, rotation, constant or input-mux choice in any round therefore corrupts nearly all 1600 output bits, and this is visible at `perm_state_o` on the done pulse, 24 cycles after acceptance. A fault in the round counter appears even sooner and more directly, as a done pulse on the wrong cycle or a busy window that is not 23 cycles long. An accepted-while-busy bug appears as a different final state, because the state register is reloaded in mid-flight. A wrong hold condition appears as `perm_state_o` drifting during idle cycles after done.

// File: rtl/keccak_pkg.sv
package keccak_pkg;

  localparam int LANE_W  = 64;
  localparam int GRID    = 5;
  localparam int NLANES  = GRID * GRID;
  localparam int STATE_W = NLANES * LANE_W;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [NLANES-1:0][LANE_W-1:0] lanes_t;

  // Rotate a lane towards its most significant end.
  function automatic lane_t rotl(lane_t v, int n);
    int k;
    k = n % LANE_W;
    if (k == 0) return v;
    return (v << k) | (v >> (LANE_W - k));
  endfunction

  // Rho offset for lane (x,y), walked along the (x,y)->(y,2x+3y) orbit.
  function automatic int rho_off(int x, int y);
    int cx, cy, nx;
    cx = 1;
    cy = 0;
    if (x == 0 && y == 0) return 0;
    for (int t = 0; t < 24; t++) begin
      if (cx == x && cy == y) return (((t + 1) * (t + 2)) / 2) % LANE_W;
      nx = cy;
      cy = (2 * cx + 3 * cy) % GRID;
      cx = nx;
    end
    return 0;
  endfunction

  // Output bit t of the degree-8 constant generator.
  function automatic logic lfsr_bit(int t);
    logic [8:0] r;
    r = 9'h001;
    for (int i = 0; i < (t % 255); i++) begin
      r = {r[7:0], 1'b0};
      if (r[8]) r = r ^ 9'h171;
    end
    return r[0];
  endfunction

  // Round constant for round rnd: bits at positions 2^j-1.
  function automatic lane_t round_const(int rnd);
    lane_t c;
    c = '0;
    for (int j = 0; j < 7; j++) begin
      if (((1 << j) - 1) < LANE_W) c[(1 << j) - 1] = lfsr_bit(j + 7 * rnd);
    end
    return c;
  endfunction

endpackage

// File: rtl/keccak_rc_gen.sv
module keccak_rc_gen
  import keccak_pkg::*;
#(
  parameter int ROUNDS = 24,
  localparam int RW    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic [RW-1:0] rnd_i,
  output lane_t         rc_o
);

  lane_t tbl [ROUNDS];

  for (genvar gi = 0; gi < ROUNDS; gi++) begin : g_rc
    localparam lane_t K = round_const(gi);
    assign tbl[gi] = K;
  end

  always_comb begin
    if (int'(rnd_i) < ROUNDS) rc_o = tbl[rnd_i];
    else                      rc_o = '0;
  end

endmodule

// File: rtl/keccak_round.sv
module keccak_round
  import keccak_pkg::*;
(
  input  lanes_t a_i,
  input  lane_t  rc_i,
  output lanes_t a_o
);

  lane_t par  [GRID];
  lane_t mix  [GRID];
  lane_t th   [NLANES];
  lane_t pb   [NLANES];
  lane_t res  [NLANES];

  // Theta: column parity and its mixing word.
  for (genvar gx = 0; gx < GRID; gx++) begin : g_par
    assign par[gx] = a_i[gx] ^ a_i[gx + 5] ^ a_i[gx + 10] ^ a_i[gx + 15] ^ a_i[gx + 20];
  end
  for (genvar gx = 0; gx < GRID; gx++) begin : g_mix
    assign mix[gx] = par[(gx + 4) % GRID] ^ rotl(par[(gx + 1) % GRID], 1);
  end

  // Theta apply, then rho rotate and pi scatter.
  for (genvar gx = 0; gx < GRID; gx++) begin : g_tx
    for (genvar gy = 0; gy < GRID; gy++) begin : g_ty
      localparam int SRC = gx + GRID * gy;
      localparam int DST = gy + GRID * ((2 * gx + 3 * gy) % GRID);
      localparam int ROT = rho_off(gx, gy);
      assign th[SRC] = a_i[SRC] ^ mix[gx];
      assign pb[DST] = rotl(th[SRC], ROT);
    end
  end

  // Chi along each row, iota on lane (0,0).
  for (genvar gx = 0; gx < GRID; gx++) begin : g_cx
    for (genvar gy = 0; gy < GRID; gy++) begin : g_cy
      localparam int P0 = gx + GRID * gy;
      localparam int P1 = ((gx + 1) % GRID) + GRID * gy;
      localparam int P2 = ((gx + 2) % GRID) + GRID * gy;
      if (P0 == 0) begin : g_iota
        assign res[P0] = pb[P0] ^ (~pb[P1] & pb[P2]) ^ rc_i;
      end else begin : g_plain
        assign res[P0] = pb[P0] ^ (~pb[P1] & pb[P2]);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NLANES; i++) a_o[i] = res[i];
  end

endmodule

// File: rtl/keccak_seq_ctrl.sv
module keccak_seq_ctrl #(
  parameter int ROUNDS = 24,
  localparam int RW    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic          step_o,
  output logic [RW-1:0] rnd_o
);

  localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

  logic          busy_q;
  logic          done_q;
  logic [RW-1:0] cnt_q;
  logic          accept;

  assign accept = go_i & ~busy_q;
  assign load_o = accept;
  assign step_o = accept | busy_q;
  assign rnd_o  = accept ? '0 : cnt_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= RW'(1);
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        done_q <= 1'b0;
        cnt_q  <= cnt_q + 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

endmodule

// File: rtl/keccak_f1600_core.sv
module keccak_f1600_core
  import keccak_pkg::*;
#(
  parameter int ROUNDS = 24,
  localparam int RW    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               perm_go_i,
  input  logic [STATE_W-1:0] perm_state_i,
  output logic               perm_busy_o,
  output logic               perm_done_o,
  output logic [STATE_W-1:0] perm_state_o
);

  logic          load;
  logic          step;
  logic [RW-1:0] rnd;
  lane_t         rc;
  lanes_t        cur_q;
  lanes_t        rin;
  lanes_t        rout;

  keccak_seq_ctrl #(.ROUNDS(ROUNDS)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (perm_go_i),
    .busy_o (perm_busy_o),
    .done_o (perm_done_o),
    .load_o (load),
    .step_o (step),
    .rnd_o  (rnd)
  );

  keccak_rc_gen #(.ROUNDS(ROUNDS)) rc_i (
    .rnd_i (rnd),
    .rc_o  (rc)
  );

  // Round 0 runs directly on the incoming word at the accepting edge.
  assign rin = load ? lanes_t'(perm_state_i) : cur_q;

  keccak_round round_i (
    .a_i  (rin),
    .rc_i (rc),
    .a_o  (rout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur_q <= '0;
    else if (step) cur_q <= rout;
  end

  assign perm_state_o = cur_q;

endmodule

// File: rtl/keccak_f1600_core_chk.sv
module keccak_f1600_core_chk #(
  parameter int ROUNDS = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic        perm_go_i,
  input logic        perm_busy_o,
  input logic        perm_done_o,
  input logic [1599:0] perm_state_o
);

  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           busy_run <= 0;
    else if (perm_busy_o) busy_run <= busy_run + 1;
    else                  busy_run <= 0;
  end

  // R4: idle go pulse is taken
  a_r4_go_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_go_i && !perm_busy_o) |=> perm_busy_o);

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    perm_done_o |=> !perm_done_o);

  // R6: done coincides with busy falling
  a_r6_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    perm_done_o |-> $fell(perm_busy_o));

  // R5, R7: busy window is exactly ROUNDS-1 cycles, stray go pulses included
  a_r5_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perm_busy_o) |-> (busy_run == ROUNDS - 1));

  // R8: idle with no go keeps the output
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!perm_busy_o && !perm_go_i) |=> $stable(perm_state_o));

endmodule

bind keccak_f1600_core keccak_f1600_core_chk #(.ROUNDS(ROUNDS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .perm_go_i    (perm_go_i),
  .perm_busy_o  (perm_busy_o),
  .perm_done_o  (perm_done_o),
  .perm_state_o (perm_state_o)
);

// File: tb/keccak_f1600_core_tb.sv
`timescale 1ns/1ps
module keccak_f1600_core_tb_top;

  logic          clk;
  logic          rst_n;
  logic          go;
  logic [1599:0] sin;
  logic          busy;
  logic          done;
  logic [1599:0] sout;

  int checks;
  int errors;
  int cyc;
  bit finished;

  logic [63:0] rcv [24];
  int rho_t [5][5] = '{'{0, 36, 3, 41, 18}, '{1, 44, 10, 45, 2}, '{62, 6, 43, 15, 61},
                       '{28, 55, 25, 21, 56}, '{27, 20, 39, 8, 14}};

  keccak_f1600_core dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .perm_go_i    (go),
    .perm_state_i (sin),
    .perm_busy_o  (busy),
    .perm_done_o  (done),
    .perm_state_o (sout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] rol(logic [63:0] v, int n);
    if (n == 0) return v;
    return (v << n) | (v >> (64 - n));
  endfunction

  task automatic build_rc();
    logic [7:0] r;
    logic       msb;
    logic       seq [168];
    r = 8'h01;
    for (int t = 0; t < 168; t++) begin
      seq[t] = r[0];
      msb = r[7];
      r = {r[6:0], 1'b0};
      if (msb) r = r ^ 8'h71;
    end
    for (int i = 0; i < 24; i++) begin
      rcv[i] = '0;
      for (int j = 0; j < 7; j++) rcv[i][(2 ** j) - 1] = seq[7 * i + j];
    end
  endtask

  function automatic logic [1599:0] ref_perm(logic [1599:0] s);
    logic [63:0] a [5][5];
    logic [63:0] b [5][5];
    logic [63:0] c [5];
    logic [63:0] d [5];
    logic [1599:0] o;
    for (int y = 0; y < 5; y++)
      for (int x = 0; x < 5; x++) a[x][y] = s[64 * (x + 5 * y) +: 64];
    for (int r = 0; r < 24; r++) begin
      for (int x = 0; x < 5; x++) c[x] = a[x][0] ^ a[x][1] ^ a[x][2] ^ a[x][3] ^ a[x][4];
      for (int x = 0; x < 5; x++) d[x] = c[(x + 4) % 5] ^ rol(c[(x + 1) % 5], 1);
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++) begin
          a[x][y] = a[x][y] ^ d[x];
          b[y][(2 * x + 3 * y) % 5] = rol(a[x][y], rho_t[x][y]);
        end
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          a[x][y] = b[x][y] ^ (~b[(x + 1) % 5][y] & b[(x + 2) % 5][y]);
      a[0][0] = a[0][0] ^ rcv[r];
    end
    for (int y = 0; y < 5; y++)
      for (int x = 0; x < 5; x++) o[64 * (x + 5 * y) +: 64] = a[x][y];
    return o;
  endfunction

  function automatic logic [1599:0] rnd_state();
    logic [1599:0] v;
    for (int i = 0; i < 50; i++) v[32 * i +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, logic [1599:0] act, logic [1599:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      for (int i = 0; i < 25; i++) begin
        if (act[64 * i +: 64] !== exp[64 * i +: 64]) begin
          $display("FAIL %s: lane %0d actual 0x%016h expected 0x%016h",
                   req, i, act[64 * i +: 64], exp[64 * i +: 64]);
          break;
        end
      end
    end
  endtask

  // Drive go with a state; return at the first negedge after the accepting edge.
  task automatic launch(logic [1599:0] s);
    @(negedge clk);
    go  = 1'b1;
    sin = s;
    @(negedge clk);
    go  = 1'b0;
  endtask

  // Count negedges from the first after acceptance until done, checking busy.
  task automatic wait_done(string req, output int n);
    bit busy_ok;
    busy_ok = 1'b1;
    n = 1;
    while (done !== 1'b1 && n < 60) begin
      if (busy !== 1'b1) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    chk({req, " busy held until done"}, 64'(busy_ok), 64'd1);
  endtask

  task automatic run_one(string req, logic [1599:0] s);
    int n;
    launch(s);
    chk("R4 busy after accept", 64'(busy), 64'd1);
    wait_done(req, n);
    chk("R5 latency to done", 64'(n), 64'd24);
    chk("R6 busy low at done", 64'(busy), 64'd0);
    chk_state(req, sout, ref_perm(s));
    @(negedge clk);
    chk("R6 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    logic [1599:0] s1, s2, zres;
    int n;
    checks = 0;
    errors = 0;
    cyc = 0;
    finished = 1'b0;
    void'($urandom(32'd1357911));
    build_rc();
    rst_n = 1'b0;
    go    = 1'b0;
    sin   = '0;

    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 64'(busy), 64'd0);
    chk("R1 done in reset", 64'(done), 64'd0);
    chk_state("R1 state in reset", sout, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk_state("R1 state after reset", sout, '0);

    // R3: model constants against known values
    chk("R3 RC0", rcv[0], 64'h0000000000000001);
    chk("R3 RC1", rcv[1], 64'h0000000000008082);
    chk("R3 RC23", rcv[23], 64'h8000000080008008);
    zres = ref_perm('0);
    chk("R3 model zero lane", zres[63:0], 64'hF1258F7940E1DDE7);

    // R3 R2: zero state, lane (0,0) in bits [63:0]
    run_one("R3 zero state", '0);
    chk("R2 lane00 of zero result", sout[63:0], 64'hF1258F7940E1DDE7);

    // R2: single bit in lane (1,2) bit 5, and all ones
    s1 = '0;
    s1[64 * (1 + 5 * 2) + 5] = 1'b1;
    run_one("R2 single bit lane(1,2)", s1);
    run_one("R3 all ones", '1);

    // R3: random states
    for (int k = 0; k < 6; k++) run_one("R3 random state", rnd_state());

    // R7: go pulses during busy are ignored
    s1 = rnd_state();
    s2 = rnd_state();
    launch(s1);
    repeat (4) @(negedge clk);
    go  = 1'b1;
    sin = s2;
    repeat (3) @(negedge clk);
    go  = 1'b0;
    sin = '0;
    n = 8;
    while (done !== 1'b1 && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk("R7 latency unchanged", 64'(n), 64'd24);
    chk_state("R7 result of first state", sout, ref_perm(s1));

    // R8: output holds while idle, input wiggling
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      sin = rnd_state();
    end
    @(negedge clk);
    chk("R8 still idle", 64'(busy), 64'd0);
    chk_state("R8 output held", sout, ref_perm(s1));

    // R9: go during the done cycle, chained on the previous output
    s1 = rnd_state();
    run_one("R9 first of pair", s1);
    launch(s1);
    wait_done("R9 first", n);
    s2 = sout;
    go  = 1'b1;
    sin = s2;
    @(negedge clk);
    go  = 1'b0;
    chk("R9 accepted in done cycle", 64'(busy), 64'd1);
    wait_done("R9 second", n);
    chk("R9 period", 64'(n), 64'd24);
    chk_state("R9 chained result", sout, ref_perm(ref_perm(s1)));

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule